// File: doc/BRIEF.md
# Protected System Clock Control Register

This block is the eight-bit clock control register of a small microcontroller, together with the logic around it. Software writes the register over a simple single-cycle bus. A write lands only while a separate protect register allows it. A write that arrives while that permission is withheld is dropped.

The register sets the following:
- the source routed to the clock output pin;
- whether the peripheral clock is gated during wait mode;
- the drive strength of the sub-oscillator;
- whether the sub-oscillator is enabled;
- whether the main oscillator is stopped;
- the divide-by-8 mode;
- the CPU clock source.

Some bits are not under plain software control. Hardware forces them to 1 when the port enable is off, on a stop-mode entry strobe, and while the main oscillator is stopped. Two further rules refuse a write that would select an unstable sub-clock, or stop the main clock while it still feeds the CPU.

The analog oscillators and the power-mode sequencer are outside the block. The block sees them only as level and strobe inputs: sub-clock stable, stop entry, and high/middle speed. Reads always return the current stored value, including any forced bits.

Top module: `sccr_top`

## Requirements
- R1: After reset the register reads 0x48: the drive-high bit (bit 3) and the divide-by-8 bit (bit 6) are 1, and every other bit is 0.
- R2: A bus write (`wr_en`=1) while `prot_wen`=0 leaves the register unchanged.
- R3: Bits 1:0 select the pin clock output, and `clkout_sel` presents them: 00 plain port, 01 sub-clock, 10 f8, 11 f32. `clkout_active` is 1 exactly when the code is not 00.
- R4: Whenever bit 4 (sub-oscillator port enable) is 0, bit 3 (sub drive high) is 1.
- R5: A `stop_entry` strobe sets bit 3 to 1 in the next cycle. If `speed_hi_mid` is 1 in the same cycle, the strobe also sets bit 6 to 1.
- R6: Whenever bit 5 (main oscillator stop) is 1, bit 6 reads 1 and `cm2_drive_hold` is 1. A write cannot clear bit 6 while bit 5 is 1.
- R7: A write with bit 7 = 1 while `sub_stable`=0 does not change bit 7. The remaining bits of that write still apply.
- R8: A write with bit 5 = 1 while the stored bit 7 is 0 does not change bit 5.
- R9: `cpu_clk_sub` equals bit 7 (1 = sub-clock). `periph_clk_en` is 0 exactly when `wait_mode`=1 and bit 2 is 1.
- R10: When a write and a forcing condition (R4, R5, R6) occur in the same cycle, the forced value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe for the register |
| wr_data | input | 8 | Bus write data |
| prot_wen | input | 1 | Write permission from the protect register |
| sub_stable | input | 1 | Sub-oscillator reports stable oscillation |
| stop_entry | input | 1 | One-cycle strobe on entry to stop mode |
| speed_hi_mid | input | 1 | The chip is in high-speed or middle-speed mode |
| wait_mode | input | 1 | The chip is in wait mode |
| rd_data | output | 8 | Current register value |
| clkout_sel | output | 2 | Pin clock output source code |
| clkout_active | output | 1 | The pin carries a clock rather than a port |
| cpu_clk_sub | output | 1 | CPU clock source: 1 = sub-clock, 0 = main clock |
| periph_clk_en | output | 1 | Peripheral clock enable |
| sub_osc_en | output | 1 | Sub-oscillator enable |
| sub_drive_hi | output | 1 | Sub-oscillator high drive |
| main_osc_stop | output | 1 | Main oscillator stop request |
| div8_mode | output | 1 | Divide-by-8 mode |
| cm2_drive_hold | output | 1 | Holds the companion drive bit of the second clock register at 1 |

## Verification
Directed writes exercise each guard on its own:
- a write with the permission withheld;
- a write with the port enable off;
- a sub-clock select while the sub-clock is unstable, and again once it is stable;
- a main-stop request from the main clock, and again from the sub-clock;
- a stop strobe that collides with a write, with the speed flag both set and clear.

Each of these cases separates one guard from plain storage. Random traffic then mixes writes, permission, stability and strobes in every combination. This shows that the guards interact correctly when several apply in one cycle, especially the forced bits winning over the data written.

// File: rtl/sccr_pkg.sv
package sccr_pkg;

    // Pin clock output source, encoded as the low two register bits
    typedef enum logic [1:0] {
        PIN_PORT = 2'b00,
        PIN_FSUB = 2'b01,
        PIN_F8   = 2'b10,
        PIN_F32  = 2'b11
    } pin_src_e;

    // Register image, most significant bit first
    typedef struct packed {
        logic     cpu_on_sub;   // b7
        logic     div8;         // b6
        logic     main_stop;    // b5
        logic     sub_en;       // b4
        logic     sub_drv_hi;   // b3
        logic     wait_gate;    // b2
        pin_src_e pin_src;      // b1:b0
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

endpackage

// File: rtl/sccr_wr_filter.sv
module sccr_wr_filter
    import sccr_pkg::*;
(
    input  ctl_t             cur,
    input  logic             wr_en,
    input  logic             prot_wen,
    input  logic             sub_stable,
    input  logic [CTL_W-1:0] wr_data,
    output ctl_t             cand
);
    ctl_t wdat;
    logic accept;

    assign wdat   = ctl_t'(wr_data);
    assign accept = wr_en && prot_wen;

    always_comb begin
        cand = cur;
        if (accept) begin
            cand = wdat;
            // Sub-clock may be chosen only once it is stable
            if (wdat.cpu_on_sub && !sub_stable) begin
                cand.cpu_on_sub = cur.cpu_on_sub;
            end
            // Main clock may not stop while it is the CPU clock
            if (wdat.main_stop && !cur.cpu_on_sub) begin
                cand.main_stop = cur.main_stop;
            end
        end
    end
endmodule

// File: rtl/sccr_force.sv
module sccr_force
    import sccr_pkg::*;
(
    input  ctl_t cand,
    input  logic stop_entry,
    input  logic speed_hi_mid,
    output ctl_t forced
);
    always_comb begin
        forced = cand;
        if (!cand.sub_en) begin
            forced.sub_drv_hi = 1'b1;
        end
        if (stop_entry) begin
            forced.sub_drv_hi = 1'b1;
            if (speed_hi_mid) begin
                forced.div8 = 1'b1;
            end
        end
        if (cand.main_stop) begin
            forced.div8 = 1'b1;
        end
    end
endmodule

// File: rtl/sccr_out_decode.sv
module sccr_out_decode
    import sccr_pkg::*;
(
    input  ctl_t       ctl,
    input  logic       wait_mode,
    output logic [1:0] clkout_sel,
    output logic       clkout_active,
    output logic       cpu_clk_sub,
    output logic       periph_clk_en,
    output logic       sub_osc_en,
    output logic       sub_drive_hi,
    output logic       main_osc_stop,
    output logic       div8_mode,
    output logic       cm2_drive_hold
);
    always_comb begin
        clkout_sel     = ctl.pin_src;
        clkout_active  = (ctl.pin_src != PIN_PORT);
        cpu_clk_sub    = ctl.cpu_on_sub;
        periph_clk_en  = !(wait_mode && ctl.wait_gate);
        sub_osc_en     = ctl.sub_en;
        sub_drive_hi   = ctl.sub_drv_hi;
        main_osc_stop  = ctl.main_stop;
        div8_mode      = ctl.div8;
        cm2_drive_hold = ctl.main_stop;
    end
endmodule

// File: rtl/sccr_top.sv
module sccr_top
    import sccr_pkg::*;
#(
    parameter logic [CTL_W-1:0] RESET_VAL = 8'h48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    input  logic             prot_wen,
    input  logic             sub_stable,
    input  logic             stop_entry,
    input  logic             speed_hi_mid,
    input  logic             wait_mode,
    output logic [CTL_W-1:0] rd_data,
    output logic [1:0]       clkout_sel,
    output logic             clkout_active,
    output logic             cpu_clk_sub,
    output logic             periph_clk_en,
    output logic             sub_osc_en,
    output logic             sub_drive_hi,
    output logic             main_osc_stop,
    output logic             div8_mode,
    output logic             cm2_drive_hold
);
    ctl_t ctl_q, ctl_d;
    ctl_t cand;
    ctl_t forced;

    sccr_wr_filter i_filter (
        .cur        (ctl_q),
        .wr_en      (wr_en),
        .prot_wen   (prot_wen),
        .sub_stable (sub_stable),
        .wr_data    (wr_data),
        .cand       (cand)
    );

    sccr_force i_force (
        .cand         (cand),
        .stop_entry   (stop_entry),
        .speed_hi_mid (speed_hi_mid),
        .forced       (forced)
    );

    always_comb begin
        ctl_d = forced;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= ctl_t'(RESET_VAL);
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rd_data = ctl_q;

    sccr_out_decode i_dec (
        .ctl            (ctl_q),
        .wait_mode      (wait_mode),
        .clkout_sel     (clkout_sel),
        .clkout_active  (clkout_active),
        .cpu_clk_sub    (cpu_clk_sub),
        .periph_clk_en  (periph_clk_en),
        .sub_osc_en     (sub_osc_en),
        .sub_drive_hi   (sub_drive_hi),
        .main_osc_stop  (main_osc_stop),
        .div8_mode      (div8_mode),
        .cm2_drive_hold (cm2_drive_hold)
    );
endmodule

// File: rtl/sccr_chk.sv
module sccr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       prot_wen,
    input logic       sub_stable,
    input logic       stop_entry,
    input logic       speed_hi_mid,
    input logic [7:0] rd_data,
    input logic       cm2_drive_hold,
    input logic       cpu_clk_sub
);
    // R2: a blocked write with no strobe changes nothing
    a_r2_blocked_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !prot_wen && !stop_entry) |=> (rd_data == $past(rd_data)));

    // R4: port disabled implies high drive
    a_r4_drive_forced: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[4] |-> rd_data[3]);

    // R5: stop strobe raises drive bit, and div8 from high/middle speed
    a_r5_stop_drive: assert property (@(posedge clk) disable iff (!rst_n)
        stop_entry |=> rd_data[3]);
    a_r5_stop_div8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_entry && speed_hi_mid) |=> rd_data[6]);

    // R6: main stop pins div8 and the companion drive hold
    a_r6_div8_pinned: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[5] |-> (rd_data[6] && cm2_drive_hold));

    // R7: unstable sub-clock cannot become the CPU clock
    a_r7_sub_unstable: assert property (@(posedge clk) disable iff (!rst_n)
        (!sub_stable && !cpu_clk_sub) |=> !cpu_clk_sub);

    // R8: main clock cannot stop while it drives the CPU
    a_r8_main_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[7] && !rd_data[5]) |=> !rd_data[5]);
endmodule

bind sccr_top sccr_chk i_sccr_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .prot_wen       (prot_wen),
    .sub_stable     (sub_stable),
    .stop_entry     (stop_entry),
    .speed_hi_mid   (speed_hi_mid),
    .rd_data        (rd_data),
    .cm2_drive_hold (cm2_drive_hold),
    .cpu_clk_sub    (cpu_clk_sub)
);

// File: tb/test_sccr_top.sv
module test_sccr_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       prot_wen = 1'b0;
    logic       sub_stable = 1'b0;
    logic       stop_entry = 1'b0;
    logic       speed_hi_mid = 1'b0;
    logic       wait_mode = 1'b0;
    logic [7:0] rd_data;
    logic [1:0] clkout_sel;
    logic       clkout_active, cpu_clk_sub, periph_clk_en, sub_osc_en;
    logic       sub_drive_hi, main_osc_stop, div8_mode, cm2_drive_hold;

    int errors = 0;
    int checks = 0;
    logic [7:0] model;
    bit done = 0;

    always #2 clk = ~clk;

    sccr_top i_sccr_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .prot_wen(prot_wen), .sub_stable(sub_stable), .stop_entry(stop_entry),
        .speed_hi_mid(speed_hi_mid), .wait_mode(wait_mode), .rd_data(rd_data),
        .clkout_sel(clkout_sel), .clkout_active(clkout_active),
        .cpu_clk_sub(cpu_clk_sub), .periph_clk_en(periph_clk_en),
        .sub_osc_en(sub_osc_en), .sub_drive_hi(sub_drive_hi),
        .main_osc_stop(main_osc_stop), .div8_mode(div8_mode),
        .cm2_drive_hold(cm2_drive_hold)
    );

    // Expected next value, written from the requirements
    function automatic logic [7:0] next_val(logic [7:0] cur, logic we, logic prot,
                                            logic [7:0] d, logic stab, logic stp, logic hm);
        logic [7:0] n;
        n = cur;
        if (we && prot) begin
            n = d;
            if (d[7] && !stab) n[7] = cur[7];     // R7
            if (d[5] && !cur[7]) n[5] = cur[5];   // R8
        end
        if (!n[4]) n[3] = 1'b1;                   // R4
        if (stp) begin                            // R5
            n[3] = 1'b1;
            if (hm) n[6] = 1'b1;
        end
        if (n[5]) n[6] = 1'b1;                    // R6
        return n;
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic outputs_check(string tag);
        check({tag, " R3 sel"}, {6'd0, clkout_sel}, {6'd0, model[1:0]});
        check({tag, " R3 act"}, {7'd0, clkout_active}, {7'd0, model[1:0] != 2'b00});
        check({tag, " R9 cpu"}, {7'd0, cpu_clk_sub}, {7'd0, model[7]});
        check({tag, " R9 per"}, {7'd0, periph_clk_en}, {7'd0, !(wait_mode && model[2])});
        check({tag, " R6 hold"}, {7'd0, cm2_drive_hold}, {7'd0, model[5]});
    endtask

    task automatic step(string tag, logic we, logic prot, logic [7:0] d,
                        logic stab, logic stp, logic hm, logic wm);
        wr_en = we; prot_wen = prot; wr_data = d; sub_stable = stab;
        stop_entry = stp; speed_hi_mid = hm; wait_mode = wm;
        @(posedge clk);
        model = next_val(model, we, prot, d, stab, stp, hm);
        @(negedge clk);
        wr_en = 1'b0; stop_entry = 1'b0;
        check(tag, rd_data, model);
    endtask

    initial begin
        void'($urandom(32'd2024));
        model = 8'h48;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset value", rd_data, 8'h48);
        outputs_check("R1");

        step("R2 blocked write", 1, 0, 8'hFF, 1, 0, 0, 0);
        check("R2 unchanged", rd_data, 8'h48);
        step("R3 write fsub", 1, 1, 8'h11, 0, 0, 0, 0);
        check("R3 value", rd_data, 8'h11);
        outputs_check("R3");
        step("R4 port off", 1, 1, 8'h02, 0, 0, 0, 0);
        check("R4 forced drive", rd_data, 8'h0A);
        step("R7 unstable", 1, 1, 8'h94, 0, 0, 0, 1);
        check("R7 bit7 kept", rd_data, 8'h14);
        outputs_check("R9 wait gate");
        step("R8 main stop from main", 1, 1, 8'h34, 1, 0, 0, 0);
        check("R8 bit5 kept", rd_data, 8'h14);
        step("R7 stable", 1, 1, 8'h90, 1, 0, 0, 0);
        check("R7 bit7 set", rd_data, 8'h90);
        step("R6 main stop", 1, 1, 8'hB0, 1, 0, 0, 0);
        check("R6 div8 pinned", rd_data, 8'hF0);
        step("R6 clear div8", 1, 1, 8'hB0, 1, 0, 0, 0);
        check("R6 div8 kept", rd_data, 8'hF0);
        outputs_check("R6");
        step("R10 stop vs write", 1, 1, 8'h10, 1, 1, 1, 0);
        check("R10 forced wins", rd_data, 8'h58);
        step("R5 stop low speed", 1, 1, 8'h10, 1, 1, 0, 0);
        check("R5 drive only", rd_data, 8'h18);

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            step("R10 random", r[0], r[1] | r[2], r[15:8], r[3], r[4] & r[5],
                 r[6], r[7]);
            if (i % 16 == 0) outputs_check("R9 random");
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule